// File: doc/BRIEF.md
# Level-Sensitive DMA Request Acceptor

This block accepts transfer requests for one DMA channel that works in single-address mode. The request comes in on an active-low, level-sensitive pin. The pin is only looked at after a write to the control register turns the channel on. While the channel is listening, a low level on the pin is caught as a held request and the block stops listening. The held request is shown to the bus arbiter. When the arbiter reports a bus break, the held request is dropped and activation begins. One cycle later the single transfer strobe fires for exactly one clock.

After the strobe, the bus is left to other masters for a programmable number of cycles. The block then starts listening to the pin again. Because the request is a level and not an edge, a pin that stays low starts the next transfer at once. The loop ends when the transfer counter reports its last transfer during the strobe. Writing the enable bit as zero stops the channel at any point.

Top module: `dma_lvl_accept`

## Requirements
- R1: While reset is low, and in the first cycle after it, `accept_o`, `bus_req_o` and `xfer_stb_o` are all 0.
- R2: A cycle with `en_wr`=1 and `en_val`=1, taken while the channel is stopped or finished, makes `accept_o`=1 from the next cycle on. While stopped, the request pin is ignored and all three outputs stay 0.
- R3: The pin goes through a 2-stage synchronizer. When `req_n`=0 is applied before clock edge k, and acceptance is open at edges k+1 and k+2, `bus_req_o` rises and `accept_o` falls after edge k+2.
- R4: Once a request is held, `bus_req_o` stays 1 until a cycle with `bus_grant`=1, whatever the pin does.
- R5: A cycle with `bus_grant`=1 while `bus_req_o`=1 makes `bus_req_o` 0 after that edge. `xfer_stb_o` is then 1 in the cycle that follows, for exactly one cycle.
- R6: After a strobe, all three outputs stay 0 for `GAP` cycles (default 2). After that, `accept_o` returns to 1.
- R7: If the pin is still low when acceptance reopens, a new request is held after the first open cycle.
- R8: `count_done`=1 during the strobe cycle sends the block to a finished state. In that state all outputs stay 0 and the pin is ignored until the next enable write.
- R9: A cycle with `en_wr`=1 and `en_val`=0 clears all three outputs from the next cycle on, from any state, and drops a held request. Later grants are ignored.
- R10: While acceptance is open and the pin stays high, `accept_o` stays 1 and no request is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 1 | Request pin, active low, level sensitive |
| en_wr | input | 1 | Control register write strobe |
| en_val | input | 1 | Enable bit value carried by the write |
| count_done | input | 1 | Transfer counter reports the last transfer |
| bus_grant | input | 1 | Bus break granted by the arbiter |
| accept_o | output | 1 | Acceptance window open, pin being sampled |
| bus_req_o | output | 1 | Held request shown to the arbiter |
| xfer_stb_o | output | 1 | Single-address transfer strobe |

## Verification
The assertions run on every cycle and check five things:
- the strobe lasts only one cycle;
- the strobe is always preceded two cycles earlier by a grant while a request was held;
- a held request persists until it is granted;
- strobes are spaced at least `GAP` cycles apart, and the cycle after a strobe is never open;
- a disable write quiets all outputs on the next cycle.

Only the bench scenarios can show the exact latency through the synchronizer, the re-triggering by a pin held low, the stop on `count_done`, and the restart after a fresh enable write.

// File: rtl/dma_lvl_pkg.sv
package dma_lvl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPEN   = 3'd1,
        ST_HELD   = 3'd2,
        ST_ACT    = 3'd3,
        ST_SINGLE = 3'd4,
        ST_REL    = 3'd5,
        ST_DONE   = 3'd6
    } acc_state_e;

    typedef struct packed {
        acc_state_e st;
        logic       open;
        logic       breq;
        logic       stb;
    } acc_regs_t;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_s_o
);
    logic [STAGES-1:0] q_q, q_d;

    assign q_d[0] = pin_i;
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        assign q_d[i] = q_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '1;
        else        q_q <= q_d;
    end

    assign pin_s_o = q_q[STAGES-1];
endmodule

// File: rtl/dma_gap_timer.sv
module dma_gap_timer #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic over_o
);
    localparam int CW = $clog2(GAP + 1);
    localparam logic [CW-1:0] LAST = CW'(GAP - 1);
    localparam logic [CW-1:0] TOP  = CW'(GAP);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                   cnt_d = '0;
        else if (run_i && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign over_o = run_i && (cnt_q >= LAST);

    a_r6_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
endmodule

// File: rtl/dma_lvl_accept.sv
module dma_lvl_accept
    import dma_lvl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAP         = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic en_wr,
    input  logic en_val,
    input  logic count_done,
    input  logic bus_grant,
    output logic accept_o,
    output logic bus_req_o,
    output logic xfer_stb_o
);
    acc_regs_t r_q, r_d;
    logic      req_s;
    logic      gap_over;
    logic      dis_wr;

    assign dis_wr = en_wr && !en_val;

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (req_n),
        .pin_s_o (req_s)
    );

    dma_gap_timer #(.GAP(GAP)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (r_q.st == ST_SINGLE),
        .run_i  (r_q.st == ST_REL),
        .over_o (gap_over)
    );

    always_comb begin
        r_d = r_q;
        if (dis_wr) begin
            r_d.st = ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_IDLE, ST_DONE: if (en_wr && en_val) r_d.st = ST_OPEN;
                ST_OPEN:          if (!req_s)          r_d.st = ST_HELD;
                ST_HELD:          if (bus_grant)       r_d.st = ST_ACT;
                ST_ACT:           r_d.st = ST_SINGLE;
                ST_SINGLE:        r_d.st = count_done ? ST_DONE : ST_REL;
                ST_REL:           if (gap_over)        r_d.st = ST_OPEN;
                default:          r_d.st = ST_IDLE;
            endcase
        end
        r_d.open = (r_d.st == ST_OPEN);
        r_d.breq = (r_d.st == ST_HELD);
        r_d.stb  = (r_d.st == ST_SINGLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, open: 1'b0, breq: 1'b0, stb: 1'b0};
        else        r_q <= r_d;
    end

    assign accept_o   = r_q.open;
    assign bus_req_o  = r_q.breq;
    assign xfer_stb_o = r_q.stb;

    // Spacing monitor for strobe-to-strobe distance
    localparam int GW = $clog2(GAP + 2);
    logic [GW-1:0] since_q;
    logic          seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (xfer_stb_o) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else if (since_q != GW'(GAP + 1)) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r5_stb_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb_o |=> !xfer_stb_o);

    a_r5_stb_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb_o |-> ($past(bus_grant, 2) && $past(bus_req_o, 2)));

    a_r4_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_grant && !dis_wr) |=> bus_req_o);

    a_r6_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb_o && seen_q) |-> (since_q >= GW'(GAP)));

    a_r6_no_open_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stb_o |=> !accept_o);

    a_r9_disable_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> (!accept_o && !bus_req_o && !xfer_stb_o));
endmodule

// File: tb/sim_dma_lvl_accept.sv
module sim_dma_lvl_accept;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1, en_wr = 1'b0, en_val = 1'b0, count_done = 1'b0, bus_grant = 1'b0;
    logic accept_o, bus_req_o, xfer_stb_o;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_lvl_accept u0 (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .en_wr(en_wr), .en_val(en_val),
        .count_done(count_done), .bus_grant(bus_grant),
        .accept_o(accept_o), .bus_req_o(bus_req_o), .xfer_stb_o(xfer_stb_o)
    );

    // {en_wr, en_val, req_n, bus_grant, count_done, exp_accept, exp_req, exp_stb}
    localparam int NV = 31;
    localparam logic [7:0] VEC [0:NV-1] = '{
        8'b11100_100, 8'b00000_100, 8'b00000_100, 8'b00100_010, 8'b00100_010,
        8'b00110_000, 8'b00100_001, 8'b00100_000, 8'b00100_000, 8'b00100_100,
        8'b00100_100, 8'b00000_100, 8'b00000_100, 8'b00000_010, 8'b00010_000,
        8'b00000_001, 8'b00000_000, 8'b00000_000, 8'b00000_100, 8'b00000_010,
        8'b00010_000, 8'b00000_001, 8'b00001_000, 8'b00000_000, 8'b00000_000,
        8'b10000_000, 8'b00000_000, 8'b11000_100, 8'b00000_010, 8'b10000_000,
        8'b00110_000
    };

    function automatic string row_tag(int i);
        if (i == 0 || i == 26 || i == 27) return "R2";
        if (i <= 3 || i == 13)            return "R3";
        if (i == 4)                       return "R4";
        if (i <= 6 || i == 20 || i == 21) return "R5";
        if (i <= 9 || (i >= 15 && i <= 18)) return "R6";
        if (i == 10)                      return "R10";
        if (i <= 14 || i == 19 || i == 28) return "R7";
        if (i <= 24)                      return "R8";
        return "R9";
    endfunction

    task automatic check3(string tag, logic [2:0] got, logic [2:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {accept,req,stb} got %b expected %b", tag, got, exp);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet in reset and just after
        repeat (3) @(negedge clk);
        check3("R1", {accept_o, bus_req_o, xfer_stb_o}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1", {accept_o, bus_req_o, xfer_stb_o}, 3'b000);

        // Vector walk: inputs before edge i, outputs checked after edge i
        for (int i = 0; i < NV; i++) begin
            {en_wr, en_val, req_n, bus_grant, count_done} = VEC[i][7:3];
            @(negedge clk);
            check3(row_tag(i), {accept_o, bus_req_o, xfer_stb_o}, VEC[i][2:0]);
        end
        {en_wr, en_val, req_n, bus_grant, count_done} = 5'b00100;

        // R2: stopped channel ignores a long low pin
        req_n = 1'b0;
        repeat (5) @(negedge clk);
        check3("R2", {accept_o, bus_req_o, xfer_stb_o}, 3'b000);

        // R9: disable during the strobe cycle, then grants ignored
        req_n = 1'b1;
        repeat (3) @(negedge clk);
        en_wr = 1'b1; en_val = 1'b1;
        @(negedge clk);
        en_wr = 1'b0; req_n = 1'b0;
        repeat (3) @(negedge clk);
        check3("R3", {accept_o, bus_req_o, xfer_stb_o}, 3'b010);
        bus_grant = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        @(negedge clk);
        check3("R5", {accept_o, bus_req_o, xfer_stb_o}, 3'b001);
        en_wr = 1'b1; en_val = 1'b0;
        @(negedge clk);
        en_wr = 1'b0;
        check3("R9", {accept_o, bus_req_o, xfer_stb_o}, 3'b000);
        bus_grant = 1'b1;
        repeat (4) @(negedge clk);
        check3("R9", {accept_o, bus_req_o, xfer_stb_o}, 3'b000);
        bus_grant = 1'b0;

        // R1: reset in the middle of a held request
        en_wr = 1'b1; en_val = 1'b1;
        @(negedge clk);
        en_wr = 1'b0;
        repeat (2) @(negedge clk);
        check3("R7", {accept_o, bus_req_o, xfer_stb_o}, 3'b010);
        rst_n = 1'b0;
        #1;
        check3("R1", {accept_o, bus_req_o, xfer_stb_o}, 3'b000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1", {accept_o, bus_req_o, xfer_stb_o}, 3'b000);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule